// File: doc/BRIEF.md
# Control Sub-Packet Processor

This block sits behind the transmit queue of a streaming radio interface. It takes the payload of a control packet as a stream of 32-bit words, one accepted word per handshake, and splits it into the sub-packets it carries. Every sub-packet starts on a word boundary. Its first word holds an opcode in bits 31:24, a byte length in bits 23:16 and the first two argument bytes in bits 15:0. The sub-packet then continues with enough words to hold the rest of the arguments and the padding, so it spans (length + 5) / 4 words in all, rounded down. The queue logic upstream has already applied any timing rules before it offers the payload here.

The processor executes the sub-packets it knows. It answers a ping with an echo. It reads registers and replies with their contents. It writes registers either whole or under a bit mask. It can also hold off the next operation for a given number of clock ticks. Each reply goes out as a sub-packet on a reply word stream, and it carries the 6-bit request identifier copied from the request. When a request packet has been fully handled, the reply stream is closed with a one-cycle flush marker. Sub-packets that ask for serial-bus transactions are handed word for word to an external request port. Any other opcode is stepped over using its length field.

Top module: `ctl_subpkt_proc`

## Requirements
- R1: After reset, in_ready is 1, rep_valid, rep_flush and ext_valid are 0, and every internal register reads as 0.
- R2: A ping header (opcode 0x00) produces, one cycle after it is accepted, exactly one reply word {0x80, 0x02, header bits 15:0}. This echoes the request ID in bits 15:10 and the ping value in bits 9:0.
- R3: A read header (opcode 0x04, request ID in bits 15:10, register number in bits 9:0) produces two consecutive reply words. The first is {0x84, 0x06, request ID, register number}. The second is the register value at the moment the header was accepted. A register number of NREG or more reads as 0.
- R4: A plain write (opcode 0x02, length 6, register number in bits 9:0 of the header) loads the following word into the register.
- R5: A masked write (opcode 0x03, length 10) sets the register to (old & ~mask) | (value & mask). The value is in the second word of the sub-packet and the mask is in the third.
- R6: A delay header (opcode 0x0C, tick count in bits 15:0) holds in_ready low for exactly that many cycles. The next word is therefore accepted no earlier than ticks + 1 cycles after the header. A count of 0 adds no stall.
- R7: Any opcode that is not otherwise decoded consumes exactly (length + 5) / 4 words (rounded down), produces no reply, changes no register, and leaves the next sub-packet to be parsed from its own header.
- R8: Opcodes 0x06 to 0x09 (serial-bus requests) show every word of the sub-packet on ext_word with ext_valid high in the cycle it is accepted. ext_first is 1 on the header word only. These opcodes produce no reply.
- R9: The word accepted with in_last ends the packet, even in the middle of a sub-packet, and the next word is parsed as a header. Exactly one rep_flush pulse follows, after the last reply word of the packet.
- R10: A write or masked write to a register number of NREG or more changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload word offered |
| in_word | input | 32 | Payload word |
| in_last | input | 1 | Offered word is the last word of the packet payload |
| in_ready | output | 1 | Word is accepted at this edge when in_valid is also high |
| rep_valid | output | 1 | Reply word valid |
| rep_word | output | 32 | Reply word |
| rep_flush | output | 1 | One-cycle marker that closes the reply payload of a packet |
| ext_valid | output | 1 | Serial-bus request word valid |
| ext_first | output | 1 | Current request word is a sub-packet header |
| ext_word | output | 32 | Serial-bus request word |

## Verification
The hardest situations to reach are words that look like headers but sit inside the argument area of a skipped or truncated sub-packet. A parser that loses its word count would execute them. The stimulus places ping headers as filler words inside unknown-opcode and serial-bus sub-packets. It also ends a packet with in_last on the header of a masked write that needs three words. The expected reply count and the register contents read back afterwards show whether the walker stayed in step. The delay stall is measured as the cycle distance between accepted words, over a sweep of tick counts.

// File: rtl/ctl_subpkt_pkg.sv
package ctl_subpkt_pkg;
  // number of words a sub-packet spans: 2 header bytes + length, padded to 4
  function automatic logic [6:0] sp_words(input logic [7:0] len);
    logic [9:0] t;
    t = ({2'b00, len} + 10'd5) >> 2;
    return t[6:0];
  endfunction

  // read-modify-write merge under a mask
  function automatic logic [31:0] mask_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int NREG = 8,
  parameter int RW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [31:0]   wval,
  input  logic [31:0]   wmask,
  input  logic [RW-1:0] raddr,
  output logic [31:0]   rdata
);
  import ctl_subpkt_pkg::*;
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [RW-1:0] LIMIT = RW'(NREG);

  logic [NREG-1:0][31:0] regs;
  logic w_hit;
  assign w_hit = we && (waddr < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '0;
    else if (w_hit) regs[waddr[AW-1:0]] <= mask_merge(regs[waddr[AW-1:0]], wval, wmask);
  end

  assign rdata = (raddr < LIMIT) ? regs[raddr[AW-1:0]] : 32'd0;

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    // R5
    masked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == RW'(i)) |=>
        regs[i] == (($past(regs[i]) & ~$past(wmask)) | ($past(wval) & $past(wmask))));
  end

  // R10
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr >= LIMIT) |=> $stable(regs));
endmodule

// File: rtl/ctl_delay.sv
module ctl_delay #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] ticks,
  output logic          busy
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= ticks;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ctl_subpkt_proc.sv
module ctl_subpkt_proc #(
  parameter int          NREG        = 8,
  parameter logic [7:0]  OP_PING     = 8'h00,
  parameter logic [7:0]  OP_PING_RPL = 8'h80,
  parameter logic [7:0]  OP_WRITE    = 8'h02,
  parameter logic [7:0]  OP_MWRITE   = 8'h03,
  parameter logic [7:0]  OP_READ     = 8'h04,
  parameter logic [7:0]  OP_READ_RPL = 8'h84,
  parameter logic [7:0]  OP_DELAY    = 8'h0C,
  parameter logic [7:0]  OP_EXT_LO   = 8'h06,
  parameter logic [7:0]  OP_EXT_HI   = 8'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic        in_last,
  output logic        in_ready,
  output logic        rep_valid,
  output logic [31:0] rep_word,
  output logic        rep_flush,
  output logic        ext_valid,
  output logic        ext_first,
  output logic [31:0] ext_word
);
  import ctl_subpkt_pkg::*;
  localparam int RW = 10;
  localparam int CW = 7;

  function automatic logic is_ext(input logic [7:0] op);
    return (op >= OP_EXT_LO) && (op <= OP_EXT_HI);
  endfunction

  // parser state
  logic          in_hdr;
  logic [CW-1:0] rem, idx;
  logic [7:0]    cur_op;
  logic [RW-1:0] cur_reg;
  logic [31:0]   val_hold;

  // reply state
  logic          pend, flush_pend;
  logic [31:0]   pend_word;

  logic          accept, dly_busy;
  logic [7:0]    hdr_op;
  logic [CW-1:0] hdr_words;
  logic          ping_fire, rd_fire, dly_fire, wr_fire, mw_val, mw_fire;
  logic [31:0]   rd_data;

  assign accept    = in_valid && in_ready;
  assign hdr_op    = in_word[31:24];
  assign hdr_words = sp_words(in_word[23:16]);
  assign in_ready  = !dly_busy && !pend && !flush_pend;

  // named events
  assign ping_fire = accept && in_hdr && hdr_op == OP_PING;
  assign rd_fire   = accept && in_hdr && hdr_op == OP_READ;
  assign dly_fire  = accept && in_hdr && hdr_op == OP_DELAY;
  assign wr_fire   = accept && !in_hdr && cur_op == OP_WRITE  && idx == CW'(1);
  assign mw_val    = accept && !in_hdr && cur_op == OP_MWRITE && idx == CW'(1);
  assign mw_fire   = accept && !in_hdr && cur_op == OP_MWRITE && idx == CW'(2);

  assign ext_valid = accept && (in_hdr ? is_ext(hdr_op) : is_ext(cur_op));
  assign ext_first = in_hdr;
  assign ext_word  = in_word;

  ctl_regfile #(.NREG(NREG), .RW(RW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire || mw_fire),
    .waddr (cur_reg),
    .wval  (wr_fire ? in_word : val_hold),
    .wmask (wr_fire ? 32'hFFFF_FFFF : in_word),
    .raddr (in_word[RW-1:0]),
    .rdata (rd_data)
  );

  ctl_delay #(.TW(16)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dly_fire),
    .ticks (in_word[15:0]),
    .busy  (dly_busy)
  );

  // sub-packet walker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hdr   <= 1'b1;
      rem      <= '0;
      idx      <= '0;
      cur_op   <= '0;
      cur_reg  <= '0;
      val_hold <= '0;
    end else if (accept) begin
      if (in_hdr) begin
        cur_op  <= hdr_op;
        cur_reg <= in_word[RW-1:0];
        idx     <= CW'(1);
        rem     <= hdr_words - CW'(1);
        in_hdr  <= in_last || (hdr_words == CW'(1));
      end else begin
        idx    <= idx + CW'(1);
        rem    <= rem - CW'(1);
        in_hdr <= in_last || (rem == CW'(1));
        if (mw_val) val_hold <= in_word;
      end
    end
  end

  // reply formatting and flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_valid  <= 1'b0;
      rep_word   <= '0;
      rep_flush  <= 1'b0;
      pend       <= 1'b0;
      pend_word  <= '0;
      flush_pend <= 1'b0;
    end else begin
      rep_valid <= 1'b0;
      rep_flush <= 1'b0;
      if (pend) begin
        rep_valid <= 1'b1;
        rep_word  <= pend_word;
        pend      <= 1'b0;
      end else if (ping_fire) begin
        rep_valid <= 1'b1;
        rep_word  <= {OP_PING_RPL, 8'd2, in_word[15:0]};
      end else if (rd_fire) begin
        rep_valid <= 1'b1;
        rep_word  <= {OP_READ_RPL, 8'd6, in_word[15:0]};
        pend      <= 1'b1;
        pend_word <= rd_data;
      end
      if (accept && in_last) flush_pend <= 1'b1;
      else if (flush_pend && !pend) begin
        rep_flush  <= 1'b1;
        flush_pend <= 1'b0;
      end
    end
  end

  // R2
  ping_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ping_fire |=> (rep_valid && rep_word[31:16] == {OP_PING_RPL, 8'd2}));
  // R3
  read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rep_valid && rep_word[31:24] == OP_READ_RPL) ##1 rep_valid);
  // R6
  delay_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_fire && in_word[15:0] != 16'd0) |=> !in_ready);
  // R9
  flush_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_flush |-> (!rep_valid && !pend));
  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_flush |=> !rep_flush);
  // R8
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |=> !rep_valid);
endmodule

// File: tb/ctl_subpkt_proc_bench.sv
module ctl_subpkt_proc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, rep_valid, rep_flush, ext_valid, ext_first;
  logic [31:0] rep_word, ext_word;

  ctl_subpkt_proc #(.NREG(NREG)) u_ctl_subpkt_proc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_last(in_last), .in_ready(in_ready), .rep_valid(rep_valid),
    .rep_word(rep_word), .rep_flush(rep_flush), .ext_valid(ext_valid),
    .ext_first(ext_first), .ext_word(ext_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0, acc_cyc = 0, flush_cnt = 0, ext_firsts = 0;
  logic [31:0] rxq[$];
  logic [31:0] exq[$];
  logic [31:0] txq[$];
  logic [31:0] model[NREG];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rep_valid) rxq.push_back(rep_word);
    if (rep_flush) flush_cnt <= flush_cnt + 1;
    if (ext_valid) begin
      exq.push_back(ext_word);
      if (ext_first) ext_firsts <= ext_firsts + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // entered just after a posedge; leaves just after the accepting posedge
  task automatic send(input logic [31:0] w, input logic last);
    in_valid = 1'b1; in_word = w; in_last = last;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    acc_cyc = cyc;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_pkt();
    int f0 = flush_cnt;
    rxq.delete();
    for (int i = 0; i < txq.size(); i++) send(txq[i], i == txq.size() - 1);
    while (flush_cnt == f0) @(posedge clk);
    #1;
    txq.delete();
  endtask

  function automatic logic [31:0] rd_hdr(input int rid, input int rn);
    return {8'h04, 8'd2, 6'(rid), 10'(rn)};
  endfunction

  task automatic read_all(input string req);
    for (int r = 0; r < NREG; r++) txq.push_back(rd_hdr(r + 40, r));
    run_pkt();
    check({req, " reply count"}, rxq.size(), 2 * NREG);
    for (int r = 0; r < NREG && 2*r+1 < rxq.size(); r++) begin
      check({req, " R3 reply header"}, rxq[2*r], {8'h84, 8'd6, 6'(r + 40), 10'(r)});
      check({req, " value"}, rxq[2*r+1], model[r]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] mask, val;
    int a0, f0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", in_ready, 1);
    check("R1 rep_valid", rep_valid, 0);
    check("R1 rep_flush", rep_flush, 0);
    check("R1 ext_valid", ext_valid, 0);
    @(posedge clk); #1;
    read_all("R1");

    // R4 plain write sweep, R10 out-of-range writes
    for (int r = 0; r < NREG; r++) begin
      val = 32'h1357_9BDF * (r + 1) ^ 32'(r << 20);
      model[r] = val;
      txq.push_back({8'h02, 8'd6, 6'd0, 10'(r)});
      txq.push_back(val);
    end
    txq.push_back({8'h02, 8'd6, 6'd0, 10'(NREG)});
    txq.push_back(32'hDEAD_BEEF);
    txq.push_back({8'h03, 8'd10, 6'd0, 10'd1023});
    txq.push_back(32'hFFFF_FFFF);
    txq.push_back(32'hFFFF_FFFF);
    run_pkt();
    check("R4 no reply to writes", rxq.size(), 0);
    read_all("R4 R10");
    txq.push_back(rd_hdr(5, NREG + 1));
    run_pkt();
    check("R3 out-of-range read", (rxq.size() == 2) ? rxq[1] : 32'hFFFF_FFFF, 0);

    // R5 masked write sweep
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < NREG; r++) begin
        mask = (32'h0F0F_00FF << (r + 4*k)) | 32'(k);
        val  = 32'hA5C3_5A3C + 32'(r * 977 + k * 31);
        model[r] = (model[r] & ~mask) | (val & mask);
        txq.push_back({8'h03, 8'd10, 6'd0, 10'(r)});
        txq.push_back(val);
        txq.push_back(mask);
      end
      run_pkt();
      read_all("R5");
    end

    // R2 ping sweep
    for (int p = 0; p < 64; p += 9) begin
      txq.push_back({8'h00, 8'd2, 6'(p), 10'(p * 13 + 7)});
      run_pkt();
      check("R2 count", rxq.size(), 1);
      check("R2 word", rxq.size() > 0 ? rxq[0] : 32'h0, {8'h80, 8'd2, 6'(p), 10'(p * 13 + 7)});
    end

    // R6 delay sweep
    for (int t = 0; t < 40; t += 7) begin
      rxq.delete();
      f0 = flush_cnt;
      send({8'h0C, 8'd2, 16'(t)}, 1'b0);
      a0 = acc_cyc;
      send({8'h00, 8'd2, 16'h0123}, 1'b1);
      check("R6 accept distance", acc_cyc - a0, t + 1);
      while (flush_cnt == f0) @(posedge clk);
      #1;
    end

    // R7 unknown opcodes skipped, ping-like filler ignored
    txq.push_back({8'h55, 8'd5, 16'h0000});
    txq.push_back({8'h00, 8'd2, 16'h1111});
    txq.push_back({8'h7E, 8'd0, 16'hFFFF});
    txq.push_back({8'h00, 8'd2, 16'h2222});
    run_pkt();
    check("R7 replies", rxq.size(), 1);
    check("R7 next header parsed", rxq.size() > 0 ? rxq[0] : 32'h0, {8'h80, 8'd2, 16'h2222});

    // R8 serial-bus requests forwarded
    exq.delete();
    f0 = ext_firsts;
    txq.push_back({8'h06, 8'd6, 16'h0050});
    txq.push_back({8'h00, 8'd2, 16'h3333});
    txq.push_back({8'h09, 8'd7, 16'h0000});
    txq.push_back(32'h0102_0304);
    txq.push_back(32'h0500_0000);
    txq.push_back({8'h00, 8'd2, 16'h4444});
    run_pkt();
    check("R8 words", exq.size(), 5);
    check("R8 firsts", ext_firsts - f0, 2);
    check("R8 arg word", exq.size() > 3 ? exq[3] : 32'h0, 32'h0102_0304);
    check("R8 only trailing ping replied", rxq.size(), 1);

    // R9 truncated masked write, then a fresh packet
    f0 = flush_cnt;
    txq.push_back({8'h03, 8'd10, 6'd0, 10'd3});
    run_pkt();
    check("R9 one flush", flush_cnt - f0, 1);
    txq.push_back({8'h00, 8'd2, 16'h5555});
    run_pkt();
    check("R9 header after truncation", rxq.size() > 0 ? rxq[0] : 32'h0, {8'h80, 8'd2, 16'h5555});
    read_all("R9");
    // R9 flush after two-word read reply
    rxq.delete();
    f0 = flush_cnt;
    send(rd_hdr(1, 2), 1'b1);
    @(negedge clk); check("R9 rep word1", {31'd0, rep_valid}, 1);
    @(negedge clk); check("R9 rep word2 no flush", {30'd0, rep_valid, rep_flush}, 2);
    @(negedge clk); check("R9 flush after reply", {30'd0, rep_valid, rep_flush}, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule